// File: doc/BRIEF.md
# Dual-Port Mailbox RAM with Cross-Port Interrupts

This block is a synchronous two-port RAM in which the two highest word addresses double as mailboxes between the two ports. Port A and port B each have their own chip enable, write strobe, address and 36-bit data buses. Each port can read and write any location on any clock edge. Read data is registered and appears one clock after the read.

Each port also has an active-low interrupt output. When port A writes the top word, port B's interrupt is raised, and it drops again when port B reads that word. The word just below the top carries messages the other way: a port B write raises port A's interrupt, and a port A read of that word clears it. The mailbox words hold ordinary data, so the value written is the message the other side reads.

A configuration input turns the mailbox function off. While it is low, both interrupt flags are cleared and held inactive, and the two top words act as plain storage. The address width is a parameter, so the same block can be built at 32K, 64K or 128K words, and the mailbox addresses always sit at the top of the chosen depth.

Top module: `dp_mailbox_ram`

## Requirements
- R1: After reset both `a_irq_n` and `b_irq_n` are high (inactive).
- R2: A write from either port with `*_ce`=1 and `*_we`=1 stores `*_wdata` at `*_addr`. A read (`*_ce`=1, `*_we`=0) returns the stored word on `*_rdata` after the next rising clock edge.
- R3: With `mbox_en`=1, a port A write to the top address (2^ADDR_W-1, all ones) drives `b_irq_n` low from the next clock edge.
- R4: With `mbox_en`=1, a port B read of the top address drives `b_irq_n` high from the next clock edge.
- R5: With `mbox_en`=1, a port B write to address 2^ADDR_W-2 drives `a_irq_n` low from the next edge, and a port A read of that address drives it high again.
- R6: Both mailbox words hold the written 36-bit data and can be read back like any other location.
- R7: If a flag's set and clear events fall in the same cycle, the flag ends up set (its interrupt output is low).
- R8: An access with chip enable low has no effect on any flag. A port A read of the top address, or a port B write to it, also leaves the flags unchanged.
- R9: While `mbox_en`=0 both interrupt outputs are high from the next edge, mailbox accesses set no flag, and the two top words behave as plain storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mbox_en | input | 1 | 1 enables the mailbox interrupts |
| a_ce | input | 1 | Port A chip enable |
| a_we | input | 1 | Port A write strobe (1 write, 0 read) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A registered read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_ce | input | 1 | Port B chip enable |
| b_we | input | 1 | Port B write strobe (1 write, 0 read) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | 36 | Port B write data |
| b_rdata | output | 36 | Port B registered read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
A flag's set event and its clear event can land on the same edge: the sending port writes the mailbox while the receiving port reads it. The bench provokes this for both directions, once with the flag already pending and once with it clear. In both cases the interrupt is expected to be low on the following cycle. A later lone read is then expected to clear it and to return the newest message.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_DATA_W = 36;

    typedef logic [MBX_DATA_W-1:0] word_t;

    typedef struct packed {
        logic pending;
    } flag_state_t;

    typedef struct packed {
        word_t a_rdata;
        word_t b_rdata;
    } rd_state_t;

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_top,
    output logic              hit_sub
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SUB_ADDR = TOP_ADDR - 1'b1;

    always_comb begin
        hit_top = (addr == TOP_ADDR);
        hit_sub = (addr == SUB_ADDR);
    end
endmodule

// File: rtl/mbx_ram_core.sv
module mbx_ram_core
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_ce,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  word_t             a_wdata,
    output word_t             a_rdata,
    input  logic              b_ce,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  word_t             b_wdata,
    output word_t             b_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    word_t     mem [DEPTH];
    rd_state_t rd_d, rd_q;

    // Storage: port B is written after port A, so it wins a same-word collision.
    always_ff @(posedge clk) begin
        if (a_ce && a_we) begin
            mem[a_addr] <= a_wdata;
        end
        if (b_ce && b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (a_ce && !a_we) begin
            rd_d.a_rdata = mem[a_addr];
        end
        if (b_ce && !b_we) begin
            rd_d.b_rdata = mem[b_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign a_rdata = rd_q.a_rdata;
    assign b_rdata = rd_q.b_rdata;
endmodule

// File: rtl/mbx_flag_ctl.sv
module mbx_flag_ctl
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.pending = 1'b0;
        end else if (set_req) begin
            st_d.pending = 1'b1;
        end else if (clr_req) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.pending;
endmodule

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mbox_en,
    input  logic              a_ce,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [35:0]       a_wdata,
    output logic [35:0]       a_rdata,
    output logic              a_irq_n,
    input  logic              b_ce,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [35:0]       b_wdata,
    output logic [35:0]       b_rdata,
    output logic              b_irq_n
);
    localparam int unsigned N_DIR = 2;

    logic a_top, a_sub, b_top, b_sub;
    logic [N_DIR-1:0] set_req, clr_req, irq_vec_n;

    mbx_addr_dec #(.ADDR_W(ADDR_W)) u_dec_a (
        .addr(a_addr), .hit_top(a_top), .hit_sub(a_sub)
    );
    mbx_addr_dec #(.ADDR_W(ADDR_W)) u_dec_b (
        .addr(b_addr), .hit_top(b_top), .hit_sub(b_sub)
    );

    mbx_ram_core #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    // Direction 0 signals port B (A writes top, B reads top).
    // Direction 1 signals port A (B writes top-1, A reads top-1).
    always_comb begin
        set_req[0] = a_ce &  a_we & a_top;
        clr_req[0] = b_ce & ~b_we & b_top;
        set_req[1] = b_ce &  b_we & b_sub;
        clr_req[1] = a_ce & ~a_we & a_sub;
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        mbx_flag_ctl u_flag (
            .clk(clk), .rst_n(rst_n), .enable(mbox_en),
            .set_req(set_req[d]), .clr_req(clr_req[d]), .irq_n(irq_vec_n[d])
        );
    end

    assign b_irq_n = irq_vec_n[0];
    assign a_irq_n = irq_vec_n[1];
endmodule

// File: rtl/dp_mailbox_ram_checker.sv
module dp_mailbox_ram_checker #(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mbox_en,
    input logic              a_ce,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_irq_n,
    input logic              b_ce,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_irq_n
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SUB = TOP - 1'b1;

    logic to_b_set, to_b_clr, to_a_set, to_a_clr;
    assign to_b_set = mbox_en && a_ce && a_we && (a_addr == TOP);
    assign to_b_clr = mbox_en && b_ce && !b_we && (b_addr == TOP);
    assign to_a_set = mbox_en && b_ce && b_we && (b_addr == SUB);
    assign to_a_clr = mbox_en && a_ce && !a_we && (a_addr == SUB);

    // R3 and R7: a set wins even against a clear in the same cycle
    a_r3_set_b: assert property (@(posedge clk) disable iff (!rst_n)
        to_b_set |=> !b_irq_n);
    a_r4_clr_b: assert property (@(posedge clk) disable iff (!rst_n)
        (to_b_clr && !to_b_set) |=> b_irq_n);
    a_r5_set_a: assert property (@(posedge clk) disable iff (!rst_n)
        to_a_set |=> !a_irq_n);
    a_r5_clr_a: assert property (@(posedge clk) disable iff (!rst_n)
        (to_a_clr && !to_a_set) |=> a_irq_n);
    a_r8_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !to_b_set && !to_b_clr) |=> $stable(b_irq_n));
    a_r8_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_en && !to_a_set && !to_a_clr) |=> $stable(a_irq_n));
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !mbox_en |=> (a_irq_n && b_irq_n));
endmodule

bind dp_mailbox_ram dp_mailbox_ram_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_irq_n(a_irq_n),
    .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_irq_n(b_irq_n)
);

// File: tb/dp_mailbox_ram_test.sv
module dp_mailbox_ram_test;
    localparam int unsigned AW = 10;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};
    localparam logic [AW-1:0] SUB = TOP - 1'b1;

    localparam int K_ARD = 0, K_BRD = 1, K_AIRQ = 2, K_BIRQ = 3;

    typedef struct {
        int          kind;
        logic [35:0] exp;
        int          due;
        string       req;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, mbox_en = 1'b1;
    logic a_ce = 0, a_we = 0, b_ce = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [35:0] a_wdata = '0, b_wdata = '0;
    logic [35:0] a_rdata, b_rdata;
    logic a_irq_n, b_irq_n;

    int errors = 0, checks = 0, cyc = 0;
    item_t sb[$];

    dp_mailbox_ram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
        .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expectation for the cycle after the next edge
    task automatic expect_next(int kind, logic [35:0] exp, string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.due = cyc + 1; it.req = req;
        sb.push_back(it);
    endtask

    task automatic drive_a(logic ce, logic we, logic [AW-1:0] ad, logic [35:0] d);
        a_ce = ce; a_we = we; a_addr = ad; a_wdata = d;
    endtask

    task automatic drive_b(logic ce, logic we, logic [AW-1:0] ad, logic [35:0] d);
        b_ce = ce; b_we = we; b_addr = ad; b_wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        drive_a(0, 0, '0, '0);
        drive_b(0, 0, '0, '0);
    endtask

    // Monitor: compare due items away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [35:0] act;
            it = sb.pop_front();
            case (it.kind)
                K_ARD:   act = a_rdata;
                K_BRD:   act = b_rdata;
                K_AIRQ:  act = {35'd0, a_irq_n};
                default: act = {35'd0, b_irq_n};
            endcase
            check(it.req, act, it.exp);
        end
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 a_irq_n", {35'd0, a_irq_n}, 36'd1);
        check("R1 b_irq_n", {35'd0, b_irq_n}, 36'd1);

        // R2: plain storage on both ports
        drive_a(1, 1, 10'd5, 36'h1_2345_6789);
        drive_b(1, 1, 10'd9, 36'hA_BCDE_F012);
        tick();
        drive_a(1, 0, 10'd9, '0);
        drive_b(1, 0, 10'd5, '0);
        expect_next(K_ARD, 36'hA_BCDE_F012, "R2 a reads b word");
        expect_next(K_BRD, 36'h1_2345_6789, "R2 b reads a word");
        tick();

        // R3: A writes top, B interrupt low
        drive_a(1, 1, TOP, 36'h0_0000_0A11);
        expect_next(K_BIRQ, 36'd0, "R3 b_irq set");
        expect_next(K_AIRQ, 36'd1, "R3 a_irq untouched");
        tick();
        // R8: A read of top does not clear; R6 mailbox data readable
        drive_a(1, 0, TOP, '0);
        expect_next(K_BIRQ, 36'd0, "R8 a read of top no clear");
        expect_next(K_ARD, 36'h0_0000_0A11, "R6 top word readable");
        tick();
        // R8: B read with ce low
        drive_b(0, 0, TOP, '0);
        expect_next(K_BIRQ, 36'd0, "R8 ce low no clear");
        tick();
        // R4: B read clears
        drive_b(1, 0, TOP, '0);
        expect_next(K_BIRQ, 36'd1, "R4 b read clears");
        expect_next(K_BRD, 36'h0_0000_0A11, "R6 b reads message");
        tick();

        // R5: B writes top-1, A interrupt
        drive_b(1, 1, SUB, 36'hF_0000_000F);
        expect_next(K_AIRQ, 36'd0, "R5 a_irq set");
        expect_next(K_BIRQ, 36'd1, "R5 b_irq untouched");
        tick();
        drive_a(1, 0, SUB, '0);
        expect_next(K_AIRQ, 36'd1, "R5 a read clears");
        expect_next(K_ARD, 36'hF_0000_000F, "R6 sub word readable");
        tick();

        // R8: B write to top and A write top with ce low set nothing
        drive_b(1, 1, TOP, 36'h0_0000_0B0B);
        expect_next(K_BIRQ, 36'd1, "R8 b write top no set");
        expect_next(K_AIRQ, 36'd1, "R8 b write top no a set");
        tick();
        drive_a(0, 1, TOP, 36'h0_0000_0DEA);
        expect_next(K_BIRQ, 36'd1, "R8 ce low no set");
        tick();
        drive_a(1, 0, TOP, '0);
        expect_next(K_ARD, 36'h0_0000_0B0B, "R8 ce low no write");
        tick();

        // R7: set and clear together, flag pending beforehand
        drive_a(1, 1, TOP, 36'h0_0000_0003);
        tick();
        drive_a(1, 1, TOP, 36'h0_0000_0004);
        drive_b(1, 0, TOP, '0);
        expect_next(K_BIRQ, 36'd0, "R7 set beats clear b");
        tick();
        drive_b(1, 0, TOP, '0);
        expect_next(K_BIRQ, 36'd1, "R4 later read clears");
        expect_next(K_BRD, 36'h0_0000_0004, "R6 newest message");
        tick();
        // R7: other direction, flag clear beforehand
        drive_b(1, 1, SUB, 36'h0_0000_0005);
        drive_a(1, 0, SUB, '0);
        expect_next(K_AIRQ, 36'd0, "R7 set beats clear a");
        tick();
        drive_a(1, 0, SUB, '0);
        expect_next(K_AIRQ, 36'd1, "R5 later read clears a");
        expect_next(K_ARD, 36'h0_0000_0005, "R6 newest message a");
        tick();

        // R9: disable drops a pending flag and turns mailboxes into storage
        drive_a(1, 1, TOP, 36'h0_0000_0006);
        expect_next(K_BIRQ, 36'd0, "R3 set before disable");
        tick();
        mbox_en = 1'b0;
        expect_next(K_BIRQ, 36'd1, "R9 disable clears b");
        tick();
        drive_a(1, 1, TOP, 36'h0_0000_0007);
        drive_b(1, 1, SUB, 36'h0_0000_0008);
        expect_next(K_BIRQ, 36'd1, "R9 no set b");
        expect_next(K_AIRQ, 36'd1, "R9 no set a");
        tick();
        drive_a(1, 0, SUB, '0);
        drive_b(1, 0, TOP, '0);
        expect_next(K_ARD, 36'h0_0000_0008, "R9 sub plain storage");
        expect_next(K_BRD, 36'h0_0000_0007, "R9 top plain storage");
        tick();
        mbox_en = 1'b1;
        expect_next(K_BIRQ, 36'd1, "R9 re-enable stays clear b");
        expect_next(K_AIRQ, 36'd1, "R9 re-enable stays clear a");
        tick();
        tick();

        check("scoreboard drained", 36'(sb.size()), 36'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule